// File: doc/BRIEF.md
# Prescaled Reload Timer Pair

This block holds two independent down-counting timers behind one small register interface: a real-time clock timer with an 8-bit prescaler and a general-purpose timer with a 16-bit prescaler. Each timer has a 32-bit counter and a 32-bit reload value. While a timer runs, its prescaler counts clock cycles, and the counter steps down by one each time the prescaler period ends. A timer whose counter is already zero when its prescaler period ends has expired. It emits a one-cycle interrupt pulse, then either reloads and keeps running or stops.

Software writes the reload values and prescaler settings, reads the counters and the cycles left in the current prescaler period, and drives both timers through one shared control word. The real-time clock timer changes its run state only when its update bit is set in the control word. The general-purpose timer takes its run state from every control write. Any write that sets a reserved bit raises a one-cycle hardware-error pulse.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset both counters read 0xFFFFFFFF, both reload values are 0xFFFFFFFF, both prescaler readbacks are 0, both timers are stopped, and irq_rtc, irq_gpt and hw_err are low.
- R2: After a control write that loads the counter with N and starts a stopped timer whose prescaler setting is P, the first interrupt pulse is visible (N+1)*(P+1) cycles after the edge that takes the write.
- R3: The real-time clock prescaler keeps only write-data bits 7:0 and the general-purpose prescaler keeps only bits 15:0.
- R4: Each expiry gives an interrupt pulse that lasts exactly one cycle.
- R5: With continuous reload set (bit 8 for the real-time clock, bit 0 for the general-purpose timer), an expiry copies the reload value into the counter and the timer keeps running, so expiries repeat every (N+1)*(P+1) cycles.
- R6: Without continuous reload, an expiry stops the timer. The counter then holds at 0 and no further pulse occurs.
- R7: A control write with the load bit set (bit 9 for the real-time clock, bit 1 for the general-purpose timer) puts the reload value into the counter at that edge, and a decrement due at the same edge is dropped.
- R8: The real-time clock run state takes the value of bit 10 only when bit 11 of the same control write is 1. Otherwise it is unchanged.
- R9: Reading a prescaler address returns the cycles left in the current prescaler period while the timer runs, and the prescaler setting while it is stopped.
- R10: hw_err pulses high for one cycle after any of these writes: a real-time clock prescaler write with data bits 31:8 not all zero, a general-purpose prescaler write with bits 31:16 not all zero, or a control write with any bit set outside 11:8 and 3:0. Writes with no reserved bit set leave hw_err low.
- R11: On every control write, the general-purpose timer takes bit 0 as continuous reload, bit 1 as load, and bit 2 as its run state.
- R12: Enabling a stopped timer starts a fresh prescaler period at the prescaler setting. Enabling a timer that is already running leaves its current period as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register select: 0 rtc counter/reload, 1 rtc prescaler, 2 gpt counter/reload, 3 gpt prescaler, 4 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr (control reads as 0) |
| irq_rtc | output | 1 | Real-time clock expiry pulse |
| irq_gpt | output | 1 | General-purpose timer expiry pulse |
| hw_err | output | 1 | Reserved-bit write pulse |

## Verification
A register write takes effect at the edge that samples bus_wr. The counter and prescaler readbacks come through a combinational path, so they show the new state in the very next cycle. irq and hw_err are registered: hw_err is due in the cycle right after the faulty write, and an interrupt is due (N+1)*(P+1) cycles after the starting write. The bench changes its inputs on falling edges and samples on falling edges. It counts whole cycles from the write edge and compares each result in the exact cycle it is due, so an early or late pulse is caught. It also samples the cycle after each pulse to confirm the pulse has dropped.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

   localparam int TMR_ADDR_W = 3;

   typedef enum logic [TMR_ADDR_W-1:0] {
      ADR_RTC_CNT = 3'd0,
      ADR_RTC_PRE = 3'd1,
      ADR_GPT_CNT = 3'd2,
      ADR_GPT_PRE = 3'd3,
      ADR_CTRL    = 3'd4
   } tmr_addr_e;

   // control word field positions; the two timers decode disjoint nibbles
   localparam int RTC_CTRL_LSB = 8;
   localparam int GPT_CTRL_LSB = 0;
   localparam logic [31:0] CTRL_LEGAL_MASK = 32'h0000_0F0F;

   typedef struct packed {
      logic wr;       // control word written this cycle
      logic cont;     // continuous reload
      logic load;     // copy reload into counter
      logic en;       // requested run state
      logic en_upd;   // run state is to take en
   } tmr_cmd_t;

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
   import dual_timer_pkg::*;
#(
   parameter bit GATED = 1'b1
) (
   input  logic           wr_i,
   input  logic [3:0]     field_i,
   output tmr_cmd_t       cmd_o
);

   assign cmd_o.wr   = wr_i;
   assign cmd_o.cont = field_i[0];
   assign cmd_o.load = field_i[1];
   assign cmd_o.en   = field_i[2];

   generate
      if (GATED) begin : g_gated
         assign cmd_o.en_upd = field_i[3];
      end else begin : g_direct
         logic unused_gate;
         assign unused_gate  = field_i[3];
         assign cmd_o.en_upd = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             start_i,
   input  logic             set_wr_i,
   input  logic [PRE_W-1:0] set_val_i,
   output logic             tick_o,
   output logic [PRE_W-1:0] remain_o
);

   localparam logic [PRE_W-1:0] PRE_ZERO = '0;
   localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

   logic [PRE_W-1:0] set_q;
   logic [PRE_W-1:0] left_q;

   generate
      if (PRE_W < 1) begin : g_bad_w
         $error("tmr_prescaler: PRE_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_q <= PRE_ZERO;
      end else if (set_wr_i) begin
         set_q <= set_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= PRE_ZERO;
      end else if (start_i) begin
         left_q <= set_q;
      end else if (run_i) begin
         if (left_q == PRE_ZERO) begin
            left_q <= set_q;
         end else begin
            left_q <= left_q - PRE_ONE;
         end
      end
   end

   assign tick_o   = run_i && (left_q == PRE_ZERO);
   assign remain_o = run_i ? left_q : set_q;

   AST_PRE_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !start_i && left_q != PRE_ZERO) |=> (left_q == $past(left_q) - PRE_ONE)); // R2

   AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !set_wr_i) |=> (left_q == set_q)); // R12

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import dual_timer_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload_wr_i,
   input  logic              pre_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  tmr_cmd_t          cmd_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [PRE_W-1:0]  pre_rd_o,
   output logic              irq_o,
   output logic              pre_err_o
);

   localparam logic [CNT_W-1:0] CNT_ONES = '1;
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic             run_q;
   logic             cont_q;
   logic             irq_q;
   logic             tick;
   logic             start;
   logic             expire;
   logic             load_now;

   generate
      if (CNT_W > DATA_W || PRE_W >= DATA_W) begin : g_bad_w
         $error("tmr_channel: CNT_W and PRE_W must fit in DATA_W");
      end
   endgenerate

   assign load_now  = cmd_i.wr && cmd_i.load;
   assign start     = cmd_i.wr && cmd_i.en_upd && cmd_i.en && !run_q;
   assign expire    = tick && (cnt_q == CNT_ZERO);
   assign pre_err_o = pre_wr_i && (|wdata_i[DATA_W-1:PRE_W]);

   tmr_prescaler #(.PRE_W(PRE_W)) presc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .start_i   (start),
      .set_wr_i  (pre_wr_i),
      .set_val_i (wdata_i[PRE_W-1:0]),
      .tick_o    (tick),
      .remain_o  (pre_rd_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= CNT_ONES;
      end else if (reload_wr_i) begin
         reload_q <= wdata_i[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cont_q <= 1'b0;
      end else if (cmd_i.wr) begin
         cont_q <= cmd_i.cont;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (cmd_i.wr && cmd_i.en_upd) begin
         run_q <= cmd_i.en;
      end else if (expire && !cont_q) begin
         run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ONES;
      end else if (load_now) begin
         cnt_q <= reload_q;
      end else if (tick) begin
         if (expire) begin
            cnt_q <= cont_q ? reload_q : CNT_ZERO;
         end else begin
            cnt_q <= cnt_q - CNT_ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= expire;
      end
   end

   assign cnt_o = cnt_q;
   assign irq_o = irq_q;

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_now |=> (cnt_q == $past(reload_q))); // R7

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !load_now) |=> (cnt_q == $past(cnt_q))); // R6

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !load_now && cnt_q != CNT_ZERO) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_ONE)); // R2

   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(cnt_q) == CNT_ZERO && $past(run_q))); // R4

   AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !$past(cont_q) && !$past(cmd_i.wr)) |-> !run_q); // R6

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
   import dual_timer_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int RTC_PRE_W = 8,
   parameter int GPT_PRE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [TMR_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  irq_rtc,
   output logic                  irq_gpt,
   output logic                  hw_err
);

   localparam logic [DATA_W-1:0] LEGAL = DATA_W'(CTRL_LEGAL_MASK);

   generate
      if (DATA_W < 12) begin : g_bad_data
         $error("dual_reload_timer: DATA_W must hold the control word");
      end
   endgenerate

   logic ctrl_wr;
   logic rtc_rel_wr;
   logic rtc_pre_wr;
   logic gpt_rel_wr;
   logic gpt_pre_wr;
   logic ctrl_err;
   logic rtc_pre_err;
   logic gpt_pre_err;
   logic err_q;

   tmr_cmd_t rtc_cmd;
   tmr_cmd_t gpt_cmd;

   logic [CNT_W-1:0]     rtc_cnt;
   logic [CNT_W-1:0]     gpt_cnt;
   logic [RTC_PRE_W-1:0] rtc_pre;
   logic [GPT_PRE_W-1:0] gpt_pre;

   assign ctrl_wr    = bus_wr && (bus_addr == ADR_CTRL);
   assign rtc_rel_wr = bus_wr && (bus_addr == ADR_RTC_CNT);
   assign rtc_pre_wr = bus_wr && (bus_addr == ADR_RTC_PRE);
   assign gpt_rel_wr = bus_wr && (bus_addr == ADR_GPT_CNT);
   assign gpt_pre_wr = bus_wr && (bus_addr == ADR_GPT_PRE);
   assign ctrl_err   = ctrl_wr && (|(bus_wdata & ~LEGAL));

   tmr_ctrl_decode #(.GATED(1'b1)) rtc_dec_i (
      .wr_i    (ctrl_wr),
      .field_i (bus_wdata[RTC_CTRL_LSB +: 4]),
      .cmd_o   (rtc_cmd)
   );

   tmr_ctrl_decode #(.GATED(1'b0)) gpt_dec_i (
      .wr_i    (ctrl_wr),
      .field_i (bus_wdata[GPT_CTRL_LSB +: 4]),
      .cmd_o   (gpt_cmd)
   );

   tmr_channel #(.CNT_W(CNT_W), .PRE_W(RTC_PRE_W), .DATA_W(DATA_W)) rtc_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reload_wr_i (rtc_rel_wr),
      .pre_wr_i    (rtc_pre_wr),
      .wdata_i     (bus_wdata),
      .cmd_i       (rtc_cmd),
      .cnt_o       (rtc_cnt),
      .pre_rd_o    (rtc_pre),
      .irq_o       (irq_rtc),
      .pre_err_o   (rtc_pre_err)
   );

   tmr_channel #(.CNT_W(CNT_W), .PRE_W(GPT_PRE_W), .DATA_W(DATA_W)) gpt_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reload_wr_i (gpt_rel_wr),
      .pre_wr_i    (gpt_pre_wr),
      .wdata_i     (bus_wdata),
      .cmd_i       (gpt_cmd),
      .cnt_o       (gpt_cnt),
      .pre_rd_o    (gpt_pre),
      .irq_o       (irq_gpt),
      .pre_err_o   (gpt_pre_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= ctrl_err || rtc_pre_err || gpt_pre_err;
      end
   end

   assign hw_err = err_q;

   always_comb begin
      case (bus_addr)
         ADR_RTC_CNT: bus_rdata = DATA_W'(rtc_cnt);
         ADR_RTC_PRE: bus_rdata = DATA_W'(rtc_pre);
         ADR_GPT_CNT: bus_rdata = DATA_W'(gpt_cnt);
         ADR_GPT_PRE: bus_rdata = DATA_W'(gpt_pre);
         default:     bus_rdata = '0;
      endcase
   end

   AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hw_err |-> $past(bus_wr)); // R10

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_err && !$past(bus_wr, 1) ) |-> 1'b0); // R10

endmodule

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        irq_rtc;
   logic        irq_gpt;
   logic        hw_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_reload_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_rtc   (irq_rtc),
      .irq_gpt   (irq_gpt),
      .hw_err    (hw_err)
   );

   typedef struct packed {
      logic        gpt;
      logic [15:0] pre;
      logic [31:0] rel;
      logic [31:0] due;
   } vec_t;

   // one-shot runs: due = (reload+1)*(prescaler+1) cycles after the start write
   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 16'd0,   32'd0, 32'd1},
      '{1'b0, 16'd3,   32'd2, 32'd12},
      '{1'b0, 16'd0,   32'd5, 32'd6},
      '{1'b1, 16'd2,   32'd4, 32'd15},
      '{1'b1, 16'd0,   32'd0, 32'd1},
      '{1'b1, 16'd9,   32'd1, 32'd20},
      '{1'b0, 16'd255, 32'd1, 32'd512}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      bus_wdata = 32'd0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int first;
      int again;
      bit extra;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, d); check("R1 rtc counter", d, 32'hFFFF_FFFF);
      rd(3'd2, d); check("R1 gpt counter", d, 32'hFFFF_FFFF);
      rd(3'd1, d); check("R1 rtc prescaler", d, 32'd0);
      rd(3'd3, d); check("R1 gpt prescaler", d, 32'd0);
      check("R1 outputs low", {29'd0, irq_rtc, irq_gpt, hw_err}, 32'd0);
      wr(3'd4, 32'h0000_0C00);
      repeat (3) @(negedge clk);
      rd(3'd0, d); check("R1 rtc runs at reset prescaler", d, 32'hFFFF_FFFC);
      wr(3'd4, 32'h0000_0800);
      wr(3'd4, 32'h0000_0200);
      rd(3'd0, d); check("R1 reload all ones", d, 32'hFFFF_FFFF);

      // R3 / R10 prescaler widths and reserved bits
      wr(3'd1, 32'h0000_01FF);
      check("R10 rtc prescaler reserved", {31'd0, hw_err}, 32'd1);
      rd(3'd1, d); check("R3 rtc prescaler 8 bits", d, 32'h0000_00FF);
      wr(3'd3, 32'h0001_2345);
      check("R10 gpt prescaler reserved", {31'd0, hw_err}, 32'd1);
      rd(3'd3, d); check("R3 gpt prescaler 16 bits", d, 32'h0000_2345);
      wr(3'd3, 32'h0000_00AB);
      check("R10 legal prescaler write", {31'd0, hw_err}, 32'd0);
      wr(3'd4, 32'h0000_1000);
      check("R10 control reserved", {31'd0, hw_err}, 32'd1);
      @(negedge clk);
      check("R10 pulse one cycle", {31'd0, hw_err}, 32'd0);
      wr(3'd4, 32'h0000_0000);
      check("R10 legal control write", {31'd0, hw_err}, 32'd0);

      // R2 R4 R6 R11 vector table of one-shot expiries
      for (int v = 0; v < NVEC; v++) begin
         wr(VECS[v].gpt ? 3'd2 : 3'd0, VECS[v].rel);
         wr(VECS[v].gpt ? 3'd3 : 3'd1, {16'd0, VECS[v].pre});
         wr(3'd4, VECS[v].gpt ? 32'h0000_0006 : 32'h0000_0E00);
         first = -1;
         for (int k = 1; k <= int'(VECS[v].due) + 3 && first < 0; k++) begin
            @(negedge clk);
            if (VECS[v].gpt ? irq_gpt : irq_rtc) first = k;
         end
         check("R2 R11 expiry cycle", first, VECS[v].due);
         @(negedge clk);
         check("R4 pulse width", {31'd0, VECS[v].gpt ? irq_gpt : irq_rtc}, 32'd0);
         extra = 1'b0;
         for (int k = 0; k < int'(VECS[v].due) + 3; k++) begin
            @(negedge clk);
            if (irq_gpt || irq_rtc) extra = 1'b1;
         end
         check("R6 no pulse after one-shot", {31'd0, extra}, 32'd0);
         rd(VECS[v].gpt ? 3'd2 : 3'd0, d); check("R6 counter held at zero", d, 32'd0);
      end

      // R7 R8 load override and gated enable
      wr(3'd1, 32'd0);
      wr(3'd0, 32'd100);
      wr(3'd4, 32'h0000_0E00);
      rd(3'd0, d); check("R7 load on start", d, 32'd100);
      repeat (3) @(negedge clk);
      rd(3'd0, d); check("R2 decrement per cycle", d, 32'd97);
      wr(3'd0, 32'd50);
      wr(3'd4, 32'h0000_0200);
      rd(3'd0, d); check("R7 load beats decrement", d, 32'd50);
      @(negedge clk);
      rd(3'd0, d); check("R8 run kept without bit 11", d, 32'd49);
      wr(3'd4, 32'h0000_0800);
      rd(3'd0, d); check("R8 stop with bit 11", d, 32'd48);
      repeat (5) @(negedge clk);
      rd(3'd0, d); check("R8 stopped holds", d, 32'd48);
      wr(3'd4, 32'h0000_0C00);
      repeat (2) @(negedge clk);
      rd(3'd0, d); check("R8 restart", d, 32'd46);
      wr(3'd4, 32'h0000_0800);

      // R9 R12 prescaler readback and period restart
      wr(3'd1, 32'd10);
      wr(3'd4, 32'h0000_0C00);
      rd(3'd1, d); check("R9 R12 fresh period", d, 32'd10);
      repeat (3) @(negedge clk);
      rd(3'd1, d); check("R9 remaining", d, 32'd7);
      wr(3'd4, 32'h0000_0C00);
      rd(3'd1, d); check("R12 running enable keeps period", d, 32'd6);
      wr(3'd4, 32'h0000_0800);
      rd(3'd1, d); check("R9 stopped shows setting", d, 32'd10);
      wr(3'd4, 32'h0000_0C00);
      rd(3'd1, d); check("R12 restart from setting", d, 32'd10);
      wr(3'd4, 32'h0000_0800);

      // R5 R11 continuous reload on the general-purpose timer
      wr(3'd3, 32'd1);
      wr(3'd2, 32'd2);
      wr(3'd4, 32'h0000_0007);
      first = -1;
      for (int k = 1; k <= 10 && first < 0; k++) begin
         @(negedge clk);
         if (irq_gpt) first = k;
      end
      check("R5 first expiry", first, 32'd6);
      again = -1;
      for (int k = 1; k <= 10 && again < 0; k++) begin
         @(negedge clk);
         if (irq_gpt) again = k;
      end
      check("R5 repeat period", again, 32'd6);
      wr(3'd4, 32'h0000_0000);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule